// File: doc/BRIEF.md
# Byte-wide PROM control-mode model

This block is a synthesizable behavioural model of the control and output logic of a byte-wide programmable read-only memory. It samples a chip-enable, an output-enable, a program strobe, a flag that says the programming supply is raised, and a flag that says address line 9 carries a high voltage. From these it picks one of seven operating modes. In each mode it either returns a byte on the data outputs with an output-enable for a tristate driver, or keeps the outputs off. A small register array stands in for the memory cells.

The array comes out of reset erased to all ones. Each program pulse can only clear bits, so the stored byte becomes the old byte ANDed with the written data. Programmers find out which part they hold through an identify mode. In that mode the block returns a maker byte or a device byte, chosen by address bit 0. Bit 7 of each byte is set so that the byte has odd parity. The output path models access time with two counters: one for consecutive cycles of output-enable low and one for chip-enable low. The outputs are driven only once both counts reach their configured thresholds.

Top module: `prom_mode_top`

## Requirements
- R1: After reset, dataOe is 0, dataOut is 0, modeCode is 0 (standby), and every array byte reads 8'hFF.
- R2: With ceN high and vppHi low, modeCode is 0 (standby) and dataOe is 0, whatever oeN is.
- R3: With ceN low, vppHi low and oeN high, modeCode is 1 (outputs off) and dataOe is 0.
- R4: With ceN and oeN low and vppHi and a9Hv low, modeCode is 2 (read) and dataOut is the array byte at index addr[3:0].
- R5: With ceN and oeN low, vppHi low and a9Hv high, modeCode is 3 (identify). dataOut is the maker byte when addr[0] is 0 and the device byte when addr[0] is 1.
- R6: Each identifier byte is {p, base}, where base is the 7-bit parameter value and p makes the count of ones in the byte odd.
- R7: idErr is 1 exactly while modeCode is 3 and some address bit other than bits 0 and 9 was 1 at the same sampling edge. Otherwise it is 0.
- R8: With ceN low, vppHi high and pgmN low, modeCode is 4 (program) and dataOe is 0. On the first edge of each such pulse, the byte at addr[3:0] becomes old AND dataIn.
- R9: With ceN and oeN low, vppHi high and pgmN high, modeCode is 5 (verify) and dataOut is the array byte at addr[3:0].
- R10: With ceN high and vppHi high, modeCode is 6 (inhibit), dataOe is 0, and the array is not written whatever pgmN and dataIn are.
- R11: modeCode, dataOut and idErr reflect the inputs sampled at the previous rising edge. In modes 2, 3 and 5, dataOe is 1 only once oeN has been sampled low at the last OE_DLY consecutive edges and ceN at the last CE_DLY consecutive edges. Defaults are OE_DLY=2 and CE_DLY=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| pgmN | input | 1 | Program strobe, active low |
| vppHi | input | 1 | Programming supply raised |
| a9Hv | input | 1 | High voltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Data to program |
| dataOut | output | 8 | Output byte, 0 while not driven |
| dataOe | output | 1 | Tristate enable for dataOut |
| modeCode | output | 3 | Current mode code |
| idErr | output | 1 | Stray address bit seen during identify |

## Verification
Every result of this block is due one rising edge after the inputs that cause it. The exception is dataOe, which needs the output-enable and chip-enable runs to reach their thresholds: with the defaults, three edges after both fall together, or two edges after output-enable alone falls when chip-enable has been low for a long time. A driver task sets inputs on the falling edge and updates a reference model of the run counters and the array. It then queues the outputs expected after the next rising edge. A monitor samples 2 ns after each rising edge and compares against the head of that queue, so every check lands on the cycle the requirement names.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_OUTOFF  = 3'd1,
    MODE_READ    = 3'd2,
    MODE_IDENT   = 3'd3,
    MODE_PROG    = 3'd4,
    MODE_VERIFY  = 3'd5,
    MODE_INHIBIT = 3'd6
  } mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // program the addressed byte at this edge
    logic useId;  // source identifier bytes instead of the array
    logic drive;  // output byte is valid and driven
  } strobe_t;

  function automatic logic [7:0] withOddParity(input logic [6:0] base);
    return {~^base, base};
  endfunction

  function automatic mode_e decodeMode(input logic ceN, input logic oeN,
                                       input logic pgmN, input logic vppHi,
                                       input logic a9Hv);
    mode_e m;
    if (ceN)              m = vppHi ? MODE_INHIBIT : MODE_STANDBY;
    else if (vppHi) begin
      if (!pgmN)          m = MODE_PROG;
      else if (!oeN)      m = MODE_VERIFY;
      else                m = MODE_OUTOFF;
    end
    else if (oeN)         m = MODE_OUTOFF;
    else if (a9Hv)        m = MODE_IDENT;
    else                  m = MODE_READ;
    return m;
  endfunction

endpackage

// File: rtl/prom_mode_ctrl.sv
module prom_mode_ctrl
  import prom_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int ID_LINE = 9,
  parameter int OE_DLY  = 2,
  parameter int CE_DLY  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              vppHi,
  input  logic              a9Hv,
  input  logic [ADDR_W-1:0] addr,
  output mode_e             modeQ,
  output strobe_t           stb,
  output logic              idErr
);

  localparam int MAX_DLY = (OE_DLY > CE_DLY) ? OE_DLY : CE_DLY;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_DLY);
  localparam logic [ADDR_W-1:0] ID_LINES = (ADDR_W'(1) << ID_LINE) | ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STRAY_MASK = ~ID_LINES;

  mode_e            nextMode;
  logic [CNT_W-1:0] ceCnt, oeCnt;
  logic             readLike;
  logic             strayBits;

  assign nextMode  = decodeMode(ceN, oeN, pgmN, vppHi, a9Hv);
  assign strayBits = |(addr & STRAY_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_STANDBY;
      ceCnt <= '0;
      oeCnt <= '0;
      idErr <= 1'b0;
    end else begin
      modeQ <= nextMode;
      ceCnt <= ceN ? '0 : ((ceCnt == CNT_MAX) ? ceCnt : ceCnt + 1'b1);
      oeCnt <= oeN ? '0 : ((oeCnt == CNT_MAX) ? oeCnt : oeCnt + 1'b1);
      idErr <= (nextMode == MODE_IDENT) && strayBits;
    end
  end

  assign readLike = (modeQ == MODE_READ) || (modeQ == MODE_IDENT) ||
                    (modeQ == MODE_VERIFY);

  always_comb begin
    stb.wrEn  = (nextMode == MODE_PROG) && (modeQ != MODE_PROG);
    stb.useId = (modeQ == MODE_IDENT);
    stb.drive = readLike && (oeCnt >= CNT_W'(OE_DLY)) && (ceCnt >= CNT_W'(CE_DLY));
  end

  // R8: one write strobe per program pulse
  p_one_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> !stb.wrEn);

  // R11: outputs never driven unless oeN was low at the last edge
  p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.drive |-> !$past(oeN));

  // R2: chip-enable high at the last edge keeps outputs off
  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(ceN) |-> !stb.drive);

  // R7: error flag only inside identify mode
  p_iderr_scope_r7: assert property (@(posedge clk) disable iff (!rstN)
    idErr |-> (modeQ == MODE_IDENT));

endmodule

// File: rtl/prom_datapath.sv
module prom_datapath
  import prom_pkg::*;
#(
  parameter int         DEPTH   = 16,
  parameter logic [6:0] MFR_ID7 = 7'h42,
  parameter logic [6:0] DEV_ID7 = 7'h0E
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [7:0]               dataIn,
  input  strobe_t                  stb,
  output logic [7:0]               dataOut
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [7:0] MFR_BYTE = withOddParity(MFR_ID7);
  localparam logic [7:0] DEV_BYTE = withOddParity(DEV_ID7);

  logic [7:0]       memQ [DEPTH];
  logic [IDX_W-1:0] idxQ;
  logic [DEPTH-1:0] rowWr;
  logic [7:0]       srcByte;

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    assign rowWr[r] = stb.wrEn && (idx == IDX_W'(r));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
      for (int r = 0; r < DEPTH; r++) memQ[r] <= 8'hFF;
    end else begin
      idxQ <= idx;
      for (int r = 0; r < DEPTH; r++)
        if (rowWr[r]) memQ[r] <= memQ[r] & dataIn;
    end
  end

  assign srcByte = stb.useId ? (idxQ[0] ? DEV_BYTE : MFR_BYTE) : memQ[idxQ];
  assign dataOut = stb.drive ? srcByte : 8'h00;

  // R6: identifier bytes always carry odd parity
  p_id_odd_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.useId |-> (^srcByte == 1'b1));

  // R8: programming only clears bits
  p_write_and_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> (memQ[$past(idx)] == ($past(memQ[idx]) & $past(dataIn))));

endmodule

// File: rtl/prom_mode_top.sv
module prom_mode_top
  import prom_pkg::*;
#(
  parameter int         ADDR_W  = 17,
  parameter int         DEPTH   = 16,
  parameter int         OE_DLY  = 2,
  parameter int         CE_DLY  = 3,
  parameter logic [6:0] MFR_ID7 = 7'h42,
  parameter logic [6:0] DEV_ID7 = 7'h0E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              vppHi,
  input  logic              a9Hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic [2:0]        modeCode,
  output logic              idErr
);

  localparam int IDX_W = $clog2(DEPTH);

  mode_e   modeQ;
  strobe_t stb;

  prom_mode_ctrl #(
    .ADDR_W(ADDR_W), .ID_LINE(9), .OE_DLY(OE_DLY), .CE_DLY(CE_DLY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
    .vppHi(vppHi), .a9Hv(a9Hv), .addr(addr),
    .modeQ(modeQ), .stb(stb), .idErr(idErr)
  );

  prom_datapath #(
    .DEPTH(DEPTH), .MFR_ID7(MFR_ID7), .DEV_ID7(DEV_ID7)
  ) u_data (
    .clk(clk), .rstN(rstN), .idx(addr[IDX_W-1:0]), .dataIn(dataIn),
    .stb(stb), .dataOut(dataOut)
  );

  assign dataOe   = stb.drive;
  assign modeCode = modeQ;

endmodule

// File: tb/prom_mode_top_test.sv
module prom_mode_top_test;

  localparam int OE_D = 2;
  localparam int CE_D = 3;
  localparam logic [6:0] MFR7 = 7'h42;
  localparam logic [6:0] DEV7 = 7'h0E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, pgmN = 1'b1, vppHi = 1'b0, a9Hv = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic [2:0]  modeCode;
  logic        idErr;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  prom_mode_top #(
    .ADDR_W(17), .DEPTH(16), .OE_DLY(OE_D), .CE_DLY(CE_D),
    .MFR_ID7(MFR7), .DEV_ID7(DEV7)
  ) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
    .vppHi(vppHi), .a9Hv(a9Hv), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .modeCode(modeCode), .idErr(idErr)
  );

  typedef struct {
    logic       oe;
    logic [7:0] dat;
    logic [2:0] mode;
    logic       err;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // reference model
  int         ceRun = 0, oeRun = 0;
  logic [2:0] prevMode = 3'd0;
  logic [7:0] refMem [16];

  function automatic logic [2:0] refMode(logic c, logic o, logic p, logic v, logic h);
    if (c) return v ? 3'd6 : 3'd0;
    if (v) return !p ? 3'd4 : (!o ? 3'd5 : 3'd1);
    if (o) return 3'd1;
    return h ? 3'd3 : 3'd2;
  endfunction

  task automatic step(input logic c, input logic o, input logic p, input logic v,
                      input logic h, input logic [16:0] a, input logic [7:0] d,
                      input string tag);
    exp_t e;
    logic [2:0] m;
    logic [6:0] b;
    @(negedge clk);
    ceN = c; oeN = o; pgmN = p; vppHi = v; a9Hv = h; addr = a; dataIn = d;
    m = refMode(c, o, p, v, h);
    ceRun = c ? 0 : (ceRun < 100 ? ceRun + 1 : ceRun);
    oeRun = o ? 0 : (oeRun < 100 ? oeRun + 1 : oeRun);
    if (m == 3'd4 && prevMode != 3'd4) refMem[a[3:0]] = refMem[a[3:0]] & d;
    prevMode = m;
    e.mode = m;
    e.oe   = (m == 3'd2 || m == 3'd3 || m == 3'd5) && oeRun >= OE_D && ceRun >= CE_D;
    b      = a[0] ? DEV7 : MFR7;
    e.dat  = !e.oe ? 8'h00 : (m == 3'd3 ? {~^b, b} : refMem[a[3:0]]);
    e.err  = (m == 3'd3) && ((a & ~17'h00201) != 17'h0);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic hold(input int n, input string tag);
    for (int i = 0; i < n; i++) step(ceN, oeN, pgmN, vppHi, a9Hv, addr, dataIn, tag);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (dataOe !== e.oe || dataOut !== e.dat || modeCode !== e.mode || idErr !== e.err) begin
          failures++;
          $display("FAIL %s actual oe=%0b dat=%02h mode=%0d err=%0b expected oe=%0b dat=%02h mode=%0d err=%0b",
                   e.tag, dataOe, dataOut, modeCode, idErr, e.oe, e.dat, e.mode, e.err);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) refMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (dataOe !== 1'b0 || dataOut !== 8'h00 || modeCode !== 3'd0 || idErr !== 1'b0) begin
      failures++;
      $display("FAIL R1 actual oe=%0b dat=%02h mode=%0d expected oe=0 dat=00 mode=0",
               dataOe, dataOut, modeCode);
    end

    // R2: standby with oeN low and high
    step(1, 0, 1, 0, 0, 17'd3, 8'h00, "R2");
    hold(2, "R2");
    step(1, 1, 1, 0, 0, 17'd3, 8'h00, "R2");

    // R4 / R11 / R1: read of erased array, both enables fall together
    step(0, 0, 1, 0, 0, 17'd5, 8'h00, "R11");
    hold(3, "R11");
    step(0, 0, 1, 0, 0, 17'd9, 8'h00, "R1");
    step(0, 0, 1, 0, 0, 17'd15, 8'h00, "R4");

    // R3: outputs off, then oeN alone falls (chip long selected)
    step(0, 1, 1, 0, 0, 17'd5, 8'h00, "R3");
    step(0, 0, 1, 0, 0, 17'd5, 8'h00, "R11");
    hold(2, "R11");

    // R8: two program pulses on byte 5
    step(0, 1, 0, 1, 0, 17'd5, 8'hA5, "R8");
    hold(2, "R8");
    step(0, 1, 1, 1, 0, 17'd5, 8'hA5, "R8");
    step(0, 1, 0, 1, 0, 17'd5, 8'h3C, "R8");
    step(0, 1, 1, 1, 0, 17'd5, 8'h3C, "R8");
    // R9: verify shows 8'h24
    step(0, 0, 1, 1, 0, 17'd5, 8'h00, "R9");
    hold(2, "R9");
    // program byte 2 then verify
    step(0, 1, 0, 1, 0, 17'd2, 8'h0F, "R8");
    step(0, 0, 1, 1, 0, 17'd2, 8'h00, "R9");
    hold(2, "R9");

    // R10: inhibit, strobe low with zero data on byte 6
    step(1, 1, 0, 1, 0, 17'd6, 8'h00, "R10");
    step(1, 0, 0, 1, 0, 17'd6, 8'h00, "R10");
    step(1, 0, 1, 1, 0, 17'd6, 8'h00, "R10");
    step(1, 0, 0, 1, 0, 17'd6, 8'h11, "R10");
    step(0, 0, 1, 0, 0, 17'd6, 8'h00, "R10");
    hold(3, "R10");

    // R4: read programmed bytes
    step(0, 0, 1, 0, 0, 17'd5, 8'h00, "R4");
    step(0, 0, 1, 0, 0, 17'd2, 8'h00, "R4");

    // R5 / R6: identify, bytes selected by addr[0]
    step(0, 0, 1, 0, 1, 17'd0, 8'h00, "R5");
    step(0, 0, 1, 0, 1, 17'd1, 8'h00, "R6");
    step(0, 0, 1, 0, 1, 17'h00200, 8'h00, "R6");
    step(0, 0, 1, 0, 1, 17'h00201, 8'h00, "R5");
    // R7: stray bits
    step(0, 0, 1, 0, 1, 17'h00010, 8'h00, "R7");
    step(0, 0, 1, 0, 1, 17'h10001, 8'h00, "R7");
    step(0, 0, 1, 0, 0, 17'h00015, 8'h00, "R7");
    step(0, 1, 1, 0, 1, 17'h00010, 8'h00, "R7");

    // R2: back to standby
    step(1, 0, 1, 0, 1, 17'd0, 8'h00, "R2");
    hold(1, "R2");

    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule